// File: doc/BRIEF.md
# Direction-Coded Tooth Pulse Generator

This block stands in for a directional speed sensor on a toothed wheel in a hardware-in-the-loop rig. A shared angle bus supplies a position value with a strobe and a rotation sign. Each time that position moves across the angle of a tooth center, the block drives one digital pulse. The pulse width depends on the direction of travel: one programmable width for forward rotation and another for reverse. Every pulse starts a programmable number of microseconds after the crossing. A receiving controller can therefore tell direction from width alone.

The host fills a small table of tooth-center angles. Crossing detection compares every table entry against the span the angle covered since the previous strobe, with modulo arithmetic, so a tooth at angle zero is handled across the end of the cycle. A single timer plays out delay and pulse. One further crossing can wait behind a pulse that is still running. Crossings beyond that are discarded and raise a sticky flag.

Top module: `tooth_dir_pulser`

## Requirements
- R1: After reset, `pulse_o` and `overrun_o` are 0. The first `ang_stb` after reset only sets the reference angle and never produces a pulse.
- R2: With `ang_rev`=0, a table angle t is crossed when (t - previous angle) mod 2^ANGLE_W lies in 1 .. (new - previous) mod 2^ANGLE_W. That is, t is in the half-open span (previous, new]. Each crossed entry yields one pulse.
- R3: With `ang_rev`=1, t is crossed when (previous - t) mod 2^ANGLE_W lies in 1 .. (previous - new) mod 2^ANGLE_W. That is, t is in [new, previous). Each crossed entry yields one pulse.
- R4: A tooth at angle 0 fires exactly once when the angle wraps through the cycle end, in either direction, and does not fire again on the next step.
- R5: A pulse that starts from an idle timer rises exactly `dly_us`*CLK_PER_US + 2 clock cycles after the clock edge that samples the crossing strobe.
- R6: The pulse stays high for `fwd_us`*CLK_PER_US cycles when the crossing strobe had `ang_rev`=0, and for `rev_us`*CLK_PER_US cycles when it had `ang_rev`=1.
- R7: A crossing that arrives while a delay or pulse is running is held. Its own delay starts on the cycle the running pulse ends, so `pulse_o` is low for exactly `dly_us`*CLK_PER_US + 1 cycles between the two pulses.
- R8: While a crossing is already held, any further crossing is dropped and sets `overrun_o` to 1. `overrun_o` then stays 1 until reset.
- R9: A width value of 0 for the active direction produces no pulse; `pulse_o` stays low.
- R10: Changes on `ang_pos` and `ang_rev` while `ang_stb` is 0 have no effect, either on the output or on the stored reference angle.
- R11: With `tbl_we`=1, entry `tbl_addr` takes the value `tbl_angle`. The next strobe uses the new value, and the old angle no longer fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_PER_US cycles per microsecond |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | IDX_W | Table entry index |
| tbl_angle | input | ANGLE_W | Tooth-center angle to store |
| ang_stb | input | 1 | Angle bus sample strobe |
| ang_pos | input | ANGLE_W | Current cycle angle |
| ang_rev | input | 1 | Rotation sign, 1 = reverse |
| dly_us | input | TIME_W | Delay from crossing to pulse, microseconds |
| fwd_us | input | TIME_W | Forward pulse width, microseconds |
| rev_us | input | TIME_W | Reverse pulse width, microseconds |
| pulse_o | output | 1 | Sensor pulse output |
| overrun_o | output | 1 | Sticky dropped-crossing flag |

## Verification
Some properties are checked on every cycle. The overrun flag never clears once set, and it only rises right after a registered crossing. No crossing is registered without a strobe. Every pulse lasts a nonzero whole number of microseconds. Both outputs are low on the first cycle out of reset.

Other behaviour only shows up in the bench's scenarios. This covers the exact rise cycle after the delay, which width goes with which direction, and the wrap through angle zero in both directions. It also covers the low gap before a held pulse, the suppression of zero-width pulses and the effect of a table rewrite.

// File: rtl/tdp_pkg.sv
`timescale 1ns/1ps
package tdp_pkg;

   // Phases of the single delay/width timer
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DELAY = 2'd1,
      ST_PULSE = 2'd2
   } tmr_state_e;

   // One crossing waiting behind the running pulse
   typedef struct packed {
      logic vld;
      logic rev;
   } hold_slot_t;

endpackage

// File: rtl/tdp_xing_detect.sv
`timescale 1ns/1ps
module tdp_xing_detect #(
   parameter int ANGLE_W = 16,
   parameter int N_TEETH = 8,
   parameter int IDX_W   = 3,
   parameter int HIT_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tbl_we,
   input  logic [IDX_W-1:0]   tbl_addr,
   input  logic [ANGLE_W-1:0] tbl_angle,
   input  logic               ang_stb,
   input  logic [ANGLE_W-1:0] ang_pos,
   input  logic               ang_rev,
   output logic [HIT_W-1:0]   hit_cnt,
   output logic               hit_rev
);

   logic [ANGLE_W-1:0] tooth_q [N_TEETH];
   logic [ANGLE_W-1:0] prev_q;
   logic               prev_vld_q;
   logic [ANGLE_W-1:0] span_w;
   logic [N_TEETH-1:0] hit_vec;
   logic [HIT_W-1:0]   hit_sum;
   logic [HIT_W-1:0]   hit_cnt_q;
   logic               hit_rev_q;

   // Distance covered since the last strobe, measured in the travel direction
   assign span_w = ang_rev ? (prev_q - ang_pos) : (ang_pos - prev_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N_TEETH; i++) tooth_q[i] <= '0;
      end else if (tbl_we) begin
         for (int i = 0; i < N_TEETH; i++)
            if (tbl_addr == IDX_W'(i)) tooth_q[i] <= tbl_angle;
      end
   end

   // One modulo comparator per tooth: hit when the tooth lies inside the span,
   // excluding the start point so a tooth is never counted twice
   for (genvar g = 0; g < N_TEETH; g++) begin : g_tooth
      logic [ANGLE_W-1:0] off_w;
      assign off_w      = ang_rev ? (prev_q - tooth_q[g]) : (tooth_q[g] - prev_q);
      assign hit_vec[g] = (off_w != '0) && (off_w <= span_w);
   end

   always_comb begin
      hit_sum = '0;
      for (int i = 0; i < N_TEETH; i++) hit_sum = hit_sum + HIT_W'(hit_vec[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q     <= '0;
         prev_vld_q <= 1'b0;
         hit_cnt_q  <= '0;
         hit_rev_q  <= 1'b0;
      end else if (ang_stb) begin
         prev_q     <= ang_pos;
         prev_vld_q <= 1'b1;
         hit_cnt_q  <= prev_vld_q ? hit_sum : '0;
         hit_rev_q  <= ang_rev;
      end else begin
         hit_cnt_q  <= '0;
      end
   end

   assign hit_cnt = hit_cnt_q;
   assign hit_rev = hit_rev_q;

endmodule

// File: rtl/tdp_pulse_timer.sv
`timescale 1ns/1ps
module tdp_pulse_timer
   import tdp_pkg::*;
#(
   parameter int TIME_W     = 16,
   parameter int CLK_PER_US = 40,
   parameter int HIT_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HIT_W-1:0]  hit_cnt,
   input  logic              hit_rev,
   input  logic [TIME_W-1:0] dly_us,
   input  logic [TIME_W-1:0] fwd_us,
   input  logic [TIME_W-1:0] rev_us,
   output logic              pulse_o,
   output logic              overrun_o
);

   localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
   localparam int CNT_W = TIME_W + PRE_W + 1;
   localparam bit POW2  = ((CLK_PER_US & (CLK_PER_US - 1)) == 0);

   logic [CNT_W-1:0] dly_clk, fwd_clk, rev_clk, wid_clk;

   // Microseconds to clocks: a shift when the ratio is a power of two
   if (POW2) begin : g_shift
      assign dly_clk = CNT_W'(dly_us) << $clog2(CLK_PER_US);
      assign fwd_clk = CNT_W'(fwd_us) << $clog2(CLK_PER_US);
      assign rev_clk = CNT_W'(rev_us) << $clog2(CLK_PER_US);
   end else begin : g_mult
      assign dly_clk = CNT_W'(dly_us) * CNT_W'(CLK_PER_US);
      assign fwd_clk = CNT_W'(fwd_us) * CNT_W'(CLK_PER_US);
      assign rev_clk = CNT_W'(rev_us) * CNT_W'(CLK_PER_US);
   end

   tmr_state_e       st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             cur_rev_q, cur_rev_d;
   hold_slot_t       hold_q, hold_d;
   logic             ovr_q, ovr_d;
   logic             finishing, free;
   logic             one_hit, two_hit, three_hit;

   assign wid_clk   = cur_rev_q ? rev_clk : fwd_clk;
   assign one_hit   = (hit_cnt != '0);
   assign two_hit   = (hit_cnt >= HIT_W'(2));
   assign three_hit = (hit_cnt >= HIT_W'(3));

   // The timer is done this cycle: end of pulse, or end of delay with zero width
   assign finishing = (cnt_q == '0) &&
                      ((st_q == ST_PULSE) || ((st_q == ST_DELAY) && (wid_clk == '0)));
   assign free      = (st_q == ST_IDLE) || finishing;

   always_comb begin
      st_d      = st_q;
      cnt_d     = cnt_q;
      cur_rev_d = cur_rev_q;
      hold_d    = hold_q;
      ovr_d     = ovr_q;

      unique case (st_q)
         ST_DELAY: begin
            if (cnt_q != '0) begin
               cnt_d = cnt_q - CNT_W'(1);
            end else if (wid_clk != '0) begin
               st_d  = ST_PULSE;
               cnt_d = wid_clk - CNT_W'(1);
            end
         end
         ST_PULSE: begin
            if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
         end
         default: ;
      endcase

      if (free) begin
         if (hold_q.vld) begin
            st_d      = ST_DELAY;
            cnt_d     = dly_clk;
            cur_rev_d = hold_q.rev;
            hold_d    = '{vld: one_hit, rev: hit_rev};
            if (two_hit) ovr_d = 1'b1;
         end else if (one_hit) begin
            st_d      = ST_DELAY;
            cnt_d     = dly_clk;
            cur_rev_d = hit_rev;
            hold_d    = '{vld: two_hit, rev: hit_rev};
            if (three_hit) ovr_d = 1'b1;
         end else if (finishing) begin
            st_d = ST_IDLE;
         end
      end else if (one_hit) begin
         if (!hold_q.vld) begin
            hold_d = '{vld: 1'b1, rev: hit_rev};
            if (two_hit) ovr_d = 1'b1;
         end else begin
            ovr_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         cnt_q     <= '0;
         cur_rev_q <= 1'b0;
         hold_q    <= '0;
         ovr_q     <= 1'b0;
      end else begin
         st_q      <= st_d;
         cnt_q     <= cnt_d;
         cur_rev_q <= cur_rev_d;
         hold_q    <= hold_d;
         ovr_q     <= ovr_d;
      end
   end

   assign pulse_o   = (st_q == ST_PULSE);
   assign overrun_o = ovr_q;

endmodule

// File: rtl/tooth_dir_pulser.sv
`timescale 1ns/1ps
module tooth_dir_pulser #(
   parameter int ANGLE_W    = 16,
   parameter int N_TEETH    = 8,
   parameter int TIME_W     = 16,
   parameter int CLK_PER_US = 40,
   localparam int IDX_W     = (N_TEETH > 1) ? $clog2(N_TEETH) : 1,
   localparam int HIT_W     = $clog2(N_TEETH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tbl_we,
   input  logic [IDX_W-1:0]   tbl_addr,
   input  logic [ANGLE_W-1:0] tbl_angle,
   input  logic               ang_stb,
   input  logic [ANGLE_W-1:0] ang_pos,
   input  logic               ang_rev,
   input  logic [TIME_W-1:0]  dly_us,
   input  logic [TIME_W-1:0]  fwd_us,
   input  logic [TIME_W-1:0]  rev_us,
   output logic               pulse_o,
   output logic               overrun_o
);

   if (ANGLE_W < 4 || ANGLE_W > 32) begin : g_bad_angle
      $error("ANGLE_W must lie in 4..32");
   end
   if (N_TEETH < 2) begin : g_bad_teeth
      $error("N_TEETH must be at least 2");
   end
   if (TIME_W < 1) begin : g_bad_time
      $error("TIME_W must be at least 1");
   end
   if (CLK_PER_US < 1) begin : g_bad_ratio
      $error("CLK_PER_US must be at least 1");
   end

   logic [HIT_W-1:0] hit_cnt;
   logic             hit_rev;

   tdp_xing_detect #(
      .ANGLE_W (ANGLE_W),
      .N_TEETH (N_TEETH),
      .IDX_W   (IDX_W),
      .HIT_W   (HIT_W)
   ) u_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .tbl_we    (tbl_we),
      .tbl_addr  (tbl_addr),
      .tbl_angle (tbl_angle),
      .ang_stb   (ang_stb),
      .ang_pos   (ang_pos),
      .ang_rev   (ang_rev),
      .hit_cnt   (hit_cnt),
      .hit_rev   (hit_rev)
   );

   tdp_pulse_timer #(
      .TIME_W     (TIME_W),
      .CLK_PER_US (CLK_PER_US),
      .HIT_W      (HIT_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit_cnt   (hit_cnt),
      .hit_rev   (hit_rev),
      .dly_us    (dly_us),
      .fwd_us    (fwd_us),
      .rev_us    (rev_us),
      .pulse_o   (pulse_o),
      .overrun_o (overrun_o)
   );

endmodule

// File: rtl/tooth_dir_pulser_chk.sv
`timescale 1ns/1ps
module tooth_dir_pulser_chk #(
   parameter int CLK_PER_US = 40,
   parameter int HIT_W      = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ang_stb,
   input logic [HIT_W-1:0] hit_cnt,
   input logic             pulse_o,
   input logic             overrun_o
);

   logic [31:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       run_q <= '0;
      else if (pulse_o) run_q <= run_q + 32'd1;
      else              run_q <= '0;
   end

   // R1: outputs are low on the first cycle out of reset
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!pulse_o && !overrun_o));

   // R10: no registered crossing without a strobe
   p_no_strobe_no_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ang_stb |=> (hit_cnt == '0));

   // R6: each pulse lasts a nonzero whole number of microseconds
   p_whole_us_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pulse_o) |-> ((run_q != 32'd0) && ((run_q % CLK_PER_US) == 0)));

   // R8: overrun is sticky
   p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_o |=> overrun_o);

   // R8: overrun only rises right after a registered crossing
   p_overrun_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun_o) |-> ($past(hit_cnt) != '0));

endmodule

bind tooth_dir_pulser tooth_dir_pulser_chk #(
   .CLK_PER_US (CLK_PER_US),
   .HIT_W      (HIT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ang_stb   (ang_stb),
   .hit_cnt   (hit_cnt),
   .pulse_o   (pulse_o),
   .overrun_o (overrun_o)
);

// File: tb/tooth_dir_pulser_bench.sv
`timescale 1ns/1ps
module tooth_dir_pulser_bench;

   localparam int AW  = 16;
   localparam int NT  = 8;
   localparam int IW  = 3;
   localparam int TW  = 16;
   localparam int CPU = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tbl_we = 1'b0;
   logic [IW-1:0] tbl_addr = '0;
   logic [AW-1:0] tbl_angle = '0;
   logic          ang_stb = 1'b0;
   logic [AW-1:0] ang_pos = '0;
   logic          ang_rev = 1'b0;
   logic [TW-1:0] dly_us = '0, fwd_us = '0, rev_us = '0;
   logic          pulse_o, overrun_o;

   tooth_dir_pulser #(.ANGLE_W(AW), .N_TEETH(NT), .TIME_W(TW), .CLK_PER_US(CPU)) u_tooth_dir_pulser (
      .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_angle(tbl_angle),
      .ang_stb(ang_stb), .ang_pos(ang_pos), .ang_rev(ang_rev),
      .dly_us(dly_us), .fwd_us(fwd_us), .rev_us(rev_us),
      .pulse_o(pulse_o), .overrun_o(overrun_o));

   initial forever #4 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // Pulse monitor, sampled on the falling edge
   int  nr = 0, nf = 0;
   int  rise_c [64];
   int  fall_c [64];
   int  wid_c  [64];
   logic prev_p = 1'b0;
   always @(negedge clk) begin
      if (pulse_o && !prev_p) begin
         rise_c[nr % 64] = cyc;
         nr = nr + 1;
      end
      if (!pulse_o && prev_p) begin
         fall_c[nf % 64] = cyc;
         wid_c[nf % 64]  = cyc - rise_c[(nr - 1) % 64];
         nf = nf + 1;
      end
      prev_p = pulse_o;
   end

   int  nchk = 0, nfail = 0;
   bit  done = 1'b0;
   logic [AW-1:0] tbl_m [NT];
   logic [AW-1:0] prevm = '0;
   bit  have_prev = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int xing(input logic [AW-1:0] p, input logic [AW-1:0] a, input bit r);
      int n = 0;
      logic [AW-1:0] span = r ? (p - a) : (a - p);
      for (int i = 0; i < NT; i++) begin
         logic [AW-1:0] off = r ? (p - tbl_m[i]) : (tbl_m[i] - p);
         if (off != '0 && off <= span) n++;
      end
      return n;
   endfunction

   task automatic wr_tooth(input int idx, input logic [AW-1:0] ang);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = IW'(idx); tbl_angle = ang;
      @(negedge clk);
      tbl_we = 1'b0;
      tbl_m[idx] = ang;
   endtask

   task automatic strobe(input logic [AW-1:0] a, input bit r, output int s);
      @(negedge clk);
      ang_pos = a; ang_rev = r; ang_stb = 1'b1;
      s = cyc + 1;
      @(negedge clk);
      ang_stb = 1'b0;
   endtask

   // Spaced step: one strobe, then wait for the whole delay and pulse to finish
   task automatic step(input logic [AW-1:0] a, input bit r, input string req);
      int s, base, n, w, expn;
      base = nr;
      n = have_prev ? xing(prevm, a, r) : 0;
      w = r ? int'(rev_us) : int'(fwd_us);
      strobe(a, r, s);
      prevm = a; have_prev = 1'b1;
      repeat (int'(dly_us) * CPU + w * CPU + 20) @(negedge clk);
      expn = (n > 0 && w != 0) ? 1 : 0;
      chk(nr - base == expn, {req, " pulse count"}, nr - base, expn);
      if (expn == 1 && nr - base == 1) begin
         chk(rise_c[base % 64] == s + 2 + int'(dly_us) * CPU, {req, " R5 rise cycle"},
             rise_c[base % 64] - s, 2 + int'(dly_us) * CPU);
         chk(wid_c[base % 64] == w * CPU, {req, " R6 width"}, wid_c[base % 64], w * CPU);
      end
   endtask

   initial begin
      int s1, base;
      void'($urandom(32'd7311));
      repeat (4) @(negedge clk);
      chk(pulse_o == 1'b0, "R1 pulse after reset", int'(pulse_o), 0);
      chk(overrun_o == 1'b0, "R1 overrun after reset", int'(overrun_o), 0);
      rst_n = 1'b1;

      for (int i = 0; i < NT; i++) wr_tooth(i, AW'(i * 8192));   // R11 table load
      dly_us = 3; fwd_us = 2; rev_us = 5;

      step(16'd8192, 1'b0, "R1 first strobe");
      step(16'd8300, 1'b0, "R2 no tooth");
      step(16'd8100, 1'b1, "R3 reverse cross");
      step(16'd8250, 1'b0, "R2 forward cross");

      // R10: wiggle the bus without a strobe
      base = nr;
      @(negedge clk); ang_pos = 16'd20000; ang_rev = 1'b1;
      repeat (6) @(negedge clk);
      ang_pos = 16'd40000; ang_rev = 1'b0;
      repeat (6) @(negedge clk);
      chk(nr == base, "R10 no pulse without strobe", nr - base, 0);
      step(16'd8260, 1'b0, "R10 reference kept");

      // R4: walk forward to the cycle end and across zero
      for (int k = 0; k < 8; k++) step(AW'(int'(prevm) + 7000), 1'b0, "R4 walk");
      step(16'd65530, 1'b0, "R4 approach");
      step(16'd6, 1'b0, "R4 forward wrap");
      step(16'd10, 1'b0, "R4 no refire");
      step(16'd65534, 1'b1, "R4 reverse wrap");
      step(16'd65500, 1'b1, "R4 no refire reverse");

      // R9: zero forward width
      fwd_us = 0;
      step(16'd1000, 1'b0, "R9 zero width");
      fwd_us = 2;

      // R7 / R8: burst of three crossings on consecutive cycles
      step(16'd8000, 1'b0, "R8 setup");
      chk(overrun_o == 1'b0, "R8 clear before burst", int'(overrun_o), 0);
      base = nr;
      @(negedge clk); ang_pos = 16'd8300; ang_rev = 1'b0; ang_stb = 1'b1; s1 = cyc + 1;
      @(negedge clk); ang_pos = 16'd16400;
      @(negedge clk); ang_pos = 16'd24700;
      @(negedge clk); ang_stb = 1'b0;
      prevm = 16'd24700;
      repeat (3 * 200 + 60) @(negedge clk);
      chk(nr - base == 2, "R8 one crossing dropped", nr - base, 2);
      chk(overrun_o == 1'b1, "R8 overrun set", int'(overrun_o), 1);
      chk(rise_c[base % 64] == s1 + 2 + 3 * CPU, "R5 first burst rise", rise_c[base % 64] - s1, 2 + 3 * CPU);
      chk(wid_c[base % 64] == 2 * CPU, "R6 first burst width", wid_c[base % 64], 2 * CPU);
      chk(rise_c[(base + 1) % 64] - fall_c[base % 64] == 3 * CPU + 1, "R7 held pulse gap",
          rise_c[(base + 1) % 64] - fall_c[base % 64], 3 * CPU + 1);
      chk(wid_c[(base + 1) % 64] == 2 * CPU, "R7 held pulse width", wid_c[(base + 1) % 64], 2 * CPU);

      // R11: move tooth 3
      wr_tooth(3, 16'd30000);
      step(16'd29000, 1'b0, "R11 old angle gone");
      step(16'd30500, 1'b0, "R11 new angle fires");
      wr_tooth(3, 16'd24576);
      step(16'd26000, 1'b1, "R11 restored");

      // Random walk with spacing below the tooth pitch
      for (int k = 0; k < 60; k++) begin
         bit r = 1'($urandom % 2);
         int d = 1 + int'($urandom % 8000);
         dly_us = TW'($urandom % 5);
         fwd_us = TW'(1 + $urandom % 6);
         rev_us = TW'(1 + $urandom % 6);
         step(r ? AW'(int'(prevm) - d) : AW'(int'(prevm) + d), r, "R6 random");
      end
      chk(overrun_o == 1'b1, "R8 overrun sticky", int'(overrun_o), 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL R1 watchdog actual=%0d expected=finish", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

endmodule